// File: doc/BRIEF.md
# DSP Link Communication Unit

This unit sits between one DSP's word-level serial link and a shared bank of FIFOs that a central router hands out. A transfer opens with a 32-bit header word from the DSP. The header names the sending port, the destination port, how many data words follow and the block number within the message. The unit latches the header and raises a request to the router. The request carries the decoded fields and this port's configured priority level. It then holds the request until the router answers with a grant. The grant gives a FIFO number and the number of words of room that FIFO has.

From that answer the unit builds one reply word for the DSP. The reply says go ahead with everything, come back later, or go ahead with only this many words. When words may be sent, the unit forwards exactly that many incoming data words into the granted FIFO. It then signals the router that the FIFO is free again and returns to waiting for the next header. After a come-back-later reply it returns at once to waiting, and the DSP must send its header again.

Top module: `lnk_comm_unit`

## Requirements
- R1: While `rst` is high and after it falls, `req_valid`, `tx_valid`, `fifo_wr` and `rel_valid` are low, and the first word received is taken as a header.
- R2: A header word is decoded MSB first: bits 31:28 are the source port, 27:24 the destination port, 23:16 the word count, 15:12 the block index; bits 11:0 are ignored. For a non-zero count, `req_valid` rises in the second cycle after the header is sampled and presents these fields.
- R3: `req_valid`, its fields and `req_prio` (equal to `port_prio`) stay constant until the cycle in which `gnt_valid` is sampled high.
- R4: When the granted room is at least the word count, the reply is 0xFFFF0001 and the full count of data words is accepted.
- R5: When the granted room is zero, the reply is 0xFFFF0002, no FIFO write or release follows, and the next word received is taken as a header.
- R6: When the granted room is non-zero but below the count, the reply has 0x80 in bits 31:24, zeros in bits 23:8 and the room in bits 7:0, and only that many data words are accepted.
- R7: Each accepted data word appears unchanged on `fifo_data` with `fifo_wr` high for one cycle, one cycle after it is sampled, with `fifo_sel` equal to the granted FIFO.
- R8: `rel_valid` pulses with `rel_fifo` equal to the granted FIFO in the same cycle as the last accepted write, and the next word received is taken as a header.
- R9: Words that arrive while a header is being decoded, while a grant is awaited or while the reply is shown are dropped: they cause no FIFO write.
- R10: A header with a word count of zero gets an 0xFFFF0001 reply in the second cycle after it is sampled, without a router request and without data.
- R11: The reply is shown with `tx_valid` high for exactly one cycle, the cycle after the grant is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_prio | input | 2 | Priority level configured for this port |
| rx_valid | input | 1 | A word from the DSP is present |
| rx_data | input | 32 | Word from the DSP |
| req_valid | output | 1 | FIFO allocation request to the router |
| req_src | output | 4 | Source port from the header |
| req_tgt | output | 4 | Destination port from the header |
| req_cnt | output | 8 | Requested word count |
| req_idx | output | 4 | Block index from the header |
| req_prio | output | 2 | Priority level of this port |
| gnt_valid | input | 1 | Router answer present |
| gnt_fifo | input | 2 | Granted FIFO number |
| gnt_space | input | 8 | Words of room in the granted FIFO |
| tx_valid | output | 1 | Reply word to the DSP present |
| tx_data | output | 32 | Reply word |
| fifo_wr | output | 1 | Write strobe to the FIFO matrix |
| fifo_sel | output | 2 | FIFO being written |
| fifo_data | output | 32 | Word being written |
| rel_valid | output | 1 | Grant release pulse |
| rel_fifo | output | 2 | FIFO being released |

## Verification
A header sampled at edge k shows up as a request, or as the zero-count reply, after edge k+1. The reply follows one edge after the grant edge. Each data word reaches the FIFO port one edge after it is sampled, and the release coincides with the last write. The bench drives every input on the falling edge and reads the outputs on the falling edge after the edge that produces them. It checks the cycles before and after each result as well, so a result that arrives early, arrives late or lasts too long counts as a failure. Grant delays, dropped stray words and a sweep over word counts against granted room are all fitted to this cycle count.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    localparam int WORD_W   = 32;
    localparam int SRC_W    = 4;
    localparam int TGT_W    = 4;
    localparam int CNT_W    = 8;
    localparam int IDX_W    = 4;
    localparam int NUM_FIFO = 4;
    localparam int FIFO_W   = $clog2(NUM_FIFO);
    localparam int PRIO_W   = FIFO_W;
    localparam int HDR_W    = SRC_W + TGT_W + CNT_W + IDX_W;
    localparam int TAG_W    = 8;
    localparam int PAD_W    = WORD_W - TAG_W - CNT_W;

    localparam logic [WORD_W-1:0] RPL_OK   = 32'hFFFF_0001;
    localparam logic [WORD_W-1:0] RPL_WAIT = 32'hFFFF_0002;
    localparam logic [TAG_W-1:0]  RPL_PART = 8'h80;

    // header fields, most significant first
    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [TGT_W-1:0] tgt;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } hdr_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  accept;
        logic              go;
    } reply_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_REQ,
        ST_REPLY,
        ST_DATA
    } st_t;

    function automatic reply_t build_reply(input logic [CNT_W-1:0] cnt,
                                           input logic [CNT_W-1:0] room);
        reply_t r;
        if (cnt == '0) begin
            r.word   = RPL_OK;
            r.accept = '0;
            r.go     = 1'b0;
        end else if (room == '0) begin
            r.word   = RPL_WAIT;
            r.accept = '0;
            r.go     = 1'b0;
        end else if (room >= cnt) begin
            r.word   = RPL_OK;
            r.accept = cnt;
            r.go     = 1'b1;
        end else begin
            r.word   = {RPL_PART, {PAD_W{1'b0}}, room};
            r.accept = room;
            r.go     = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/lnk_hdr_reg.sv
module lnk_hdr_reg
    import lnk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [HDR_W-1:0] hdr_bits,
    output hdr_t             hdr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
        end else if (load) begin
            hdr_q <= hdr_t'(hdr_bits);
        end
    end
endmodule

// File: rtl/lnk_reply_unit.sv
module lnk_reply_unit
    import lnk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  room,
    input  logic [FIFO_W-1:0] fifo_in,
    output logic [WORD_W-1:0] reply_word,
    output logic [CNT_W-1:0]  accept,
    output logic              go,
    output logic [FIFO_W-1:0] fifo_q
);
    reply_t next_r;
    reply_t cur_r;

    always_comb begin
        next_r = build_reply(cnt, room);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_r  <= '0;
            fifo_q <= '0;
        end else if (load) begin
            cur_r  <= next_r;
            fifo_q <= fifo_in;
        end
    end

    assign reply_word = cur_r.word;
    assign accept     = cur_r.accept;
    assign go         = cur_r.go;
endmodule

// File: rtl/lnk_data_mover.sv
module lnk_data_mover
    import lnk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  accept,
    input  logic              active,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              last,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              rel_valid
);
    logic [CNT_W-1:0] remain;
    logic             take;

    assign take = active && rx_valid;
    assign last = take && (remain == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain    <= '0;
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
            rel_valid <= 1'b0;
        end else begin
            fifo_wr   <= take;
            rel_valid <= last;
            if (take) begin
                fifo_data <= rx_data;
            end
            if (start) begin
                remain <= accept;
            end else if (take) begin
                remain <= remain - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/lnk_comm_unit.sv
module lnk_comm_unit
    import lnk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PRIO_W-1:0] port_prio,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              req_valid,
    output logic [SRC_W-1:0]  req_src,
    output logic [TGT_W-1:0]  req_tgt,
    output logic [CNT_W-1:0]  req_cnt,
    output logic [IDX_W-1:0]  req_idx,
    output logic [PRIO_W-1:0] req_prio,
    input  logic              gnt_valid,
    input  logic [FIFO_W-1:0] gnt_fifo,
    input  logic [CNT_W-1:0]  gnt_space,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    output logic              fifo_wr,
    output logic [FIFO_W-1:0] fifo_sel,
    output logic [WORD_W-1:0] fifo_data,
    output logic              rel_valid,
    output logic [FIFO_W-1:0] rel_fifo
);
    st_t              st_q, st_d;
    hdr_t             hdr_q;
    logic             hdr_load;
    logic             zero_cnt;
    logic             reply_load;
    logic [CNT_W-1:0] accept;
    logic             go;
    logic             last;
    logic [FIFO_W-1:0] fifo_q;
    logic [WORD_W-1:0] reply_word;

    assign hdr_load   = (st_q == ST_IDLE) && rx_valid;
    assign zero_cnt   = (hdr_q.cnt == '0);
    assign reply_load = ((st_q == ST_CTRL) && zero_cnt) ||
                        ((st_q == ST_REQ) && gnt_valid);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (rx_valid) st_d = ST_CTRL;
            ST_CTRL:  st_d = zero_cnt ? ST_REPLY : ST_REQ;
            ST_REQ:   if (gnt_valid) st_d = ST_REPLY;
            ST_REPLY: st_d = go ? ST_DATA : ST_IDLE;
            ST_DATA:  if (last) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    lnk_hdr_reg u_hdr (
        .clk      (clk),
        .rst      (rst),
        .load     (hdr_load),
        .hdr_bits (rx_data[WORD_W-1 -: HDR_W]),
        .hdr_q    (hdr_q)
    );

    lnk_reply_unit u_reply (
        .clk        (clk),
        .rst        (rst),
        .load       (reply_load),
        .cnt        (hdr_q.cnt),
        .room       (gnt_space),
        .fifo_in    (gnt_fifo),
        .reply_word (reply_word),
        .accept     (accept),
        .go         (go),
        .fifo_q     (fifo_q)
    );

    lnk_data_mover u_mover (
        .clk       (clk),
        .rst       (rst),
        .start     (st_q == ST_REPLY),
        .accept    (accept),
        .active    (st_q == ST_DATA),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .last      (last),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .rel_valid (rel_valid)
    );

    assign req_valid = (st_q == ST_REQ);
    assign req_src   = hdr_q.src;
    assign req_tgt   = hdr_q.tgt;
    assign req_cnt   = hdr_q.cnt;
    assign req_idx   = hdr_q.idx;
    assign req_prio  = port_prio;
    assign tx_valid  = (st_q == ST_REPLY);
    assign tx_data   = reply_word;
    assign fifo_sel  = fifo_q;
    assign rel_fifo  = fifo_q;
endmodule

// File: rtl/lnk_comm_unit_chk.sv
module lnk_comm_unit_chk
    import lnk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [SRC_W-1:0]  req_src,
    input logic [TGT_W-1:0]  req_tgt,
    input logic [CNT_W-1:0]  req_cnt,
    input logic [IDX_W-1:0]  req_idx,
    input logic [PRIO_W-1:0] req_prio,
    input logic              gnt_valid,
    input logic              tx_valid,
    input logic [WORD_W-1:0] tx_data,
    input logic              fifo_wr,
    input logic              rel_valid
);
    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (tx_valid && tx_data != RPL_WAIT) begin
            open_q <= 1'b1;
        end else if (rel_valid || req_valid) begin
            open_q <= 1'b0;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !gnt_valid) |=> (req_valid &&
            $stable({req_src, req_tgt, req_cnt, req_idx, req_prio}))); // R3

    AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> !tx_valid); // R11

    AST_WAIT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_data == RPL_WAIT) |=> (!fifo_wr && !rel_valid)); // R5

    AST_REPLY_CODE: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_data == RPL_OK || tx_data == RPL_WAIT ||
            (tx_data[WORD_W-1 -: TAG_W] == RPL_PART &&
             tx_data[WORD_W-TAG_W-1:CNT_W] == '0))); // R6

    AST_WRITE_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> open_q); // R7

    AST_RELEASE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> fifo_wr); // R8

    AST_NO_REQ_REPLY_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !tx_valid); // R11
endmodule

bind lnk_comm_unit lnk_comm_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_tgt   (req_tgt),
    .req_cnt   (req_cnt),
    .req_idx   (req_idx),
    .req_prio  (req_prio),
    .gnt_valid (gnt_valid),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .fifo_wr   (fifo_wr),
    .rel_valid (rel_valid)
);

// File: tb/tb_lnk_comm_unit.sv
module tb_lnk_comm_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  port_prio;
    logic        rx_valid;
    logic [31:0] rx_data;
    logic        req_valid;
    logic [3:0]  req_src, req_tgt, req_idx;
    logic [7:0]  req_cnt;
    logic [1:0]  req_prio;
    logic        gnt_valid;
    logic [1:0]  gnt_fifo;
    logic [7:0]  gnt_space;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        fifo_wr;
    logic [1:0]  fifo_sel;
    logic [31:0] fifo_data;
    logic        rel_valid;
    logic [1:0]  rel_fifo;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    lnk_comm_unit dut (
        .clk(clk), .rst(rst), .port_prio(port_prio),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .req_valid(req_valid), .req_src(req_src), .req_tgt(req_tgt),
        .req_cnt(req_cnt), .req_idx(req_idx), .req_prio(req_prio),
        .gnt_valid(gnt_valid), .gnt_fifo(gnt_fifo), .gnt_space(gnt_space),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .fifo_wr(fifo_wr), .fifo_sel(fifo_sel), .fifo_data(fifo_data),
        .rel_valid(rel_valid), .rel_fifo(rel_fifo)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_outputs(input string req);
        chk(req, "req_valid", 32'(req_valid), 0);
        chk(req, "tx_valid",  32'(tx_valid), 0);
        chk(req, "fifo_wr",   32'(fifo_wr), 0);
        chk(req, "rel_valid", 32'(rel_valid), 0);
    endtask

    task automatic check_req(input string req, input logic [31:0] hdr,
                             input logic [1:0] prio);
        chk(req, "req_valid", 32'(req_valid), 1);
        chk(req, "req_src", 32'(req_src), 32'(hdr[31:28]));
        chk(req, "req_tgt", 32'(req_tgt), 32'(hdr[27:24]));
        chk(req, "req_cnt", 32'(req_cnt), 32'(hdr[23:16]));
        chk(req, "req_idx", 32'(req_idx), 32'(hdr[15:12]));
        chk(req, "req_prio", 32'(req_prio), 32'(prio));
    endtask

    task automatic run_txn(input int cnt, input int room, input int dly,
                           input bit junk, input logic [1:0] fifo,
                           input logic [1:0] prio, input int tag);
        logic [31:0] hdr;
        logic [31:0] exp_reply;
        int          acc;
        hdr = {4'(tag), 4'(tag + 5), 8'(cnt), 4'(tag + 9), 12'hA5C};
        if (cnt == 0) begin
            exp_reply = 32'hFFFF_0001; acc = 0;
        end else if (room == 0) begin
            exp_reply = 32'hFFFF_0002; acc = 0;
        end else if (room >= cnt) begin
            exp_reply = 32'hFFFF_0001; acc = cnt;
        end else begin
            exp_reply = {8'h80, 16'h0000, 8'(room)}; acc = room;
        end
        port_prio = prio;
        rx_valid = 1'b1; rx_data = hdr;
        @(negedge clk);
        // header being decoded: a stray word here must be dropped (R9)
        rx_valid = junk; rx_data = 32'hDEAD_0001;
        chk("R2", "req_valid early", 32'(req_valid), 0);
        @(negedge clk);
        rx_valid = junk; rx_data = 32'hDEAD_0002;
        if (cnt == 0) begin
            chk("R10", "tx_valid", 32'(tx_valid), 1);
            chk("R10", "tx_data", tx_data, 32'hFFFF_0001);
            chk("R10", "req_valid", 32'(req_valid), 0);
            @(negedge clk);
            rx_valid = 1'b0;
            chk("R11", "tx_valid drop", 32'(tx_valid), 0);
            chk("R10", "fifo_wr", 32'(fifo_wr), 0);
            @(negedge clk);
            chk("R9", "fifo_wr", 32'(fifo_wr), 0);
            return;
        end
        check_req("R2", hdr, prio);
        for (int d = 0; d < dly; d++) begin
            @(negedge clk);
            check_req("R3", hdr, prio);
            chk("R9", "fifo_wr while waiting", 32'(fifo_wr), 0);
        end
        gnt_valid = 1'b1; gnt_space = 8'(room); gnt_fifo = fifo;
        @(negedge clk);
        gnt_valid = 1'b0; gnt_space = 8'hxx;
        rx_valid = junk; rx_data = 32'hDEAD_0003;
        chk(exp_reply == 32'hFFFF_0002 ? "R5" : (acc == cnt ? "R4" : "R6"),
            "reply", tx_data, exp_reply);
        chk("R11", "tx_valid", 32'(tx_valid), 1);
        chk("R3", "req_valid drop", 32'(req_valid), 0);
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R11", "tx_valid drop", 32'(tx_valid), 0);
        chk("R9", "fifo_wr after reply", 32'(fifo_wr), 0);
        if (acc == 0) begin
            @(negedge clk);
            chk("R5", "fifo_wr", 32'(fifo_wr), 0);
            chk("R5", "rel_valid", 32'(rel_valid), 0);
            chk("R5", "req_valid", 32'(req_valid), 0);
            return;
        end
        for (int i = 0; i < acc; i++) begin
            rx_valid = 1'b1; rx_data = 32'h1234_0000 + 32'(i * 7) + 32'(tag << 20);
            @(negedge clk);
            chk("R7", "fifo_wr", 32'(fifo_wr), 1);
            chk("R7", "fifo_data", fifo_data,
                32'h1234_0000 + 32'(i * 7) + 32'(tag << 20));
            chk("R7", "fifo_sel", 32'(fifo_sel), 32'(fifo));
            chk("R8", "rel_valid", 32'(rel_valid), 32'(i == acc - 1));
            if (i == acc - 1) chk("R8", "rel_fifo", 32'(rel_fifo), 32'(fifo));
        end
        rx_valid = 1'b0;
        @(negedge clk);
        chk("R8", "fifo_wr after release", 32'(fifo_wr), 0);
        chk("R8", "rel_valid drop", 32'(rel_valid), 0);
        chk("R8", "req_valid idle", 32'(req_valid), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        int cnts[5]  = '{0, 1, 2, 5, 40};
        int rooms[5] = '{0, 1, 3, 40, 255};
        rst = 1'b1; port_prio = 2'd0; rx_valid = 1'b0; rx_data = '0;
        gnt_valid = 1'b0; gnt_fifo = '0; gnt_space = '0;
        repeat (3) @(negedge clk);
        idle_outputs("R1");
        rst = 1'b0;
        @(negedge clk);
        idle_outputs("R1");

        for (int ci = 0; ci < 5; ci++) begin
            for (int si = 0; si < 5; si++) begin
                run_txn(cnts[ci], rooms[si], (ci + si) % 3, 1'((ci + si) % 2),
                        2'((ci + si) % 4), 2'(si % 4), ci * 5 + si);
            end
        end

        // full count equals room exactly
        run_txn(7, 7, 1, 1'b1, 2'd3, 2'd2, 3);
        // largest count, large grant delay
        run_txn(255, 255, 4, 1'b0, 2'd1, 2'd3, 11);

        // reset in the middle of a request
        rx_valid = 1'b1; rx_data = 32'h1268_3000;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        chk("R1", "req_valid before reset", 32'(req_valid), 1);
        rst = 1'b1;
        @(negedge clk);
        idle_outputs("R1");
        rst = 1'b0;
        @(negedge clk);
        idle_outputs("R1");
        run_txn(3, 2, 0, 1'b0, 2'd2, 2'd1, 6);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule